// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Clock

This block keeps wall-clock time as 48-bit seconds and a 30-bit nanosecond count. On every reference clock edge it moves time forward by a programmable step. The step is an integer number of nanoseconds plus a fraction given as a numerator over a denominator. For example, a step of 2.5 ns is an integer part of 2 with a numerator equal to half the denominator. A remainder accumulator collects the fractional parts. When that remainder reaches the denominator, the edge gets one extra nanosecond. When nanoseconds reach one billion, the excess carries into the seconds.

Software uses a small register port. It writes staged values first: nanoseconds with a sign flag, the upper 16 and lower 32 bits of the seconds, and the step integer, numerator and denominator. None of these touch the running clock until a commit register is written. One bit of the commit register loads an absolute time, another adds a signed nanosecond offset, and a third installs the new step. Reading the nanoseconds captures the seconds at the same moment, so a read of three words returns one consistent instant. A zero denominator is flagged and stops the clock from advancing.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the time is zero seconds and zero nanoseconds, the active step is integer 8, numerator 0, denominator 1, and `period_err` is low. Read addresses: 0 returns nanoseconds, 1 returns seconds bits 47:32, 2 returns seconds bits 31:0, 3/4/5 return the active step integer/numerator/denominator.
- R2: With a nonzero denominator and numerator below denominator, the time k edges after a step commit has advanced by integer×k + floor(numerator×k / denominator) nanoseconds.
- R3: The fractional remainder always stays below the active denominator when the numerator is below it.
- R4: Nanoseconds stay below 1,000,000,000. Each crossing carries into the seconds, and the seconds wrap modulo 2^48.
- R5: Writes to staging addresses 0 (nanoseconds, bit 31 negative flag), 1, 2, 3, 4 and 5 leave the time and the active step unchanged until address 7 is written.
- R6: Writing address 7 with bit 0 set replaces the time at that edge with the staged seconds and nanoseconds, with no step added. A staged nanosecond value of one billion or more carries into the seconds.
- R7: Writing address 7 with bit 1 set (and bit 0 clear) adds that edge's step plus or minus the staged magnitude (bits 29:0, negative when bit 31 is set). The result carries or borrows up to two seconds. When bit 0 is also set, the offset is dropped.
- R8: Writing address 7 with bit 2 set installs the staged step and clears the remainder. That edge still advances by the old step.
- R9: A zero active denominator raises `period_err` and freezes the time. Loads and offsets still apply while it is frozen.
- R10: A read of address 0 with `rd_en` high captures the seconds. Addresses 1 and 2 return the captured value until the next such read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (captures seconds on address 0) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| period_err | output | 1 | Active denominator is zero |

## Verification
Two things can land on the same edge: an offset commit, and the nanosecond rollover that the step and the fractional carry produce. The bench provokes this by installing a 2.5 ns step and loading a time a few nanoseconds below the second boundary. It then commits a positive offset at once, and in another case commits an offset together with a new step. A large negative offset against a small nanosecond value forces a double borrow. Every result is compared with a bench model that keeps time as one total nanosecond count, built from the closed-form step sum.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
   localparam int unsigned NS_PER_SEC = 1_000_000_000;

   typedef enum logic [2:0] {
      ADR_NS       = 3'd0,
      ADR_SEC_UP   = 3'd1,
      ADR_SEC_LOW  = 3'd2,
      ADR_STEP_INT = 3'd3,
      ADR_STEP_NUM = 3'd4,
      ADR_STEP_DEN = 3'd5,
      ADR_SPARE    = 3'd6,
      ADR_COMMIT   = 3'd7
   } tod_addr_e;

   localparam int BIT_LOAD   = 0;
   localparam int BIT_OFFSET = 1;
   localparam int BIT_PERIOD = 2;
   localparam int BIT_NEG    = 31;

   typedef struct packed {
      logic period;
      logic offset;
      logic load;
   } commit_t;
endpackage

// File: rtl/ptp_shadow_regs.sv
module ptp_shadow_regs
   import ptp_tod_pkg::*;
#(
   parameter int NS_W     = 30,
   parameter int SEC_UP_W = 16,
   parameter int SEC_W    = 48,
   parameter int QUO_W    = 8,
   parameter int FRAC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   output logic [NS_W-1:0]   st_ns,
   output logic              st_neg,
   output logic [SEC_W-1:0]  st_sec,
   output logic [QUO_W-1:0]  st_quo,
   output logic [FRAC_W-1:0] st_num,
   output logic [FRAC_W-1:0] st_den,
   output commit_t           commit
);
   localparam int SEC_LO_W = SEC_W - SEC_UP_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_ns  <= '0;
         st_neg <= 1'b0;
         st_sec <= '0;
         st_quo <= '0;
         st_num <= '0;
         st_den <= '0;
      end else if (wr_en) begin
         case (tod_addr_e'(wr_addr))
            ADR_NS: begin
               st_ns  <= wr_data[NS_W-1:0];
               st_neg <= wr_data[BIT_NEG];
            end
            ADR_SEC_UP:   st_sec[SEC_W-1:SEC_LO_W] <= wr_data[SEC_UP_W-1:0];
            ADR_SEC_LOW:  st_sec[SEC_LO_W-1:0]     <= wr_data[SEC_LO_W-1:0];
            ADR_STEP_INT: st_quo <= wr_data[QUO_W-1:0];
            ADR_STEP_NUM: st_num <= wr_data[FRAC_W-1:0];
            ADR_STEP_DEN: st_den <= wr_data[FRAC_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      commit = '0;
      if (wr_en && tod_addr_e'(wr_addr) == ADR_COMMIT) begin
         commit.load   = wr_data[BIT_LOAD];
         commit.offset = wr_data[BIT_OFFSET];
         commit.period = wr_data[BIT_PERIOD];
      end
   end
endmodule

// File: rtl/ptp_frac_accum.sv
module ptp_frac_accum #(
   parameter int FRAC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clear,
   input  logic [FRAC_W-1:0] num,
   input  logic [FRAC_W-1:0] den,
   output logic              carry
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;
   logic [FRAC_W:0]   wrapped;

   always_comb begin
      sum     = {1'b0, acc_q} + {1'b0, num};
      carry   = run && (sum >= {1'b0, den});
      wrapped = carry ? (sum - {1'b0, den}) : sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) acc_q <= '0;
      else if (run)        acc_q <= wrapped[FRAC_W-1:0];
   end

   AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      (den != '0 && num < den) |-> (acc_q < den)); // R3
endmodule

// File: rtl/ptp_tod_norm.sv
module ptp_tod_norm
   import ptp_tod_pkg::*;
#(
   parameter int SEC_W = 48,
   parameter int NS_W  = 30,
   parameter int T_W   = 34
) (
   input  logic [SEC_W-1:0]        base_sec,
   input  logic signed [T_W-1:0]   t_ns,
   output logic [SEC_W-1:0]        sec_out,
   output logic [NS_W-1:0]         ns_out
);
   localparam logic signed [T_W-1:0] ONE_S = T_W'(NS_PER_SEC);
   localparam logic signed [T_W-1:0] TWO_S = T_W'(2 * 64'(NS_PER_SEC));

   logic signed [T_W-1:0] ns_full;
   logic unused_hi;

   always_comb begin
      if (t_ns >= TWO_S) begin
         ns_full = t_ns - TWO_S;
         sec_out = base_sec + SEC_W'(2);
      end else if (t_ns >= ONE_S) begin
         ns_full = t_ns - ONE_S;
         sec_out = base_sec + SEC_W'(1);
      end else if (t_ns >= 0) begin
         ns_full = t_ns;
         sec_out = base_sec;
      end else if (t_ns >= -ONE_S) begin
         ns_full = t_ns + ONE_S;
         sec_out = base_sec - SEC_W'(1);
      end else begin
         ns_full = t_ns + TWO_S;
         sec_out = base_sec - SEC_W'(2);
      end
   end

   assign ns_out    = ns_full[NS_W-1:0];
   assign unused_hi = ^ns_full[T_W-1:NS_W];
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
   import ptp_tod_pkg::*;
#(
   parameter int SEC_W         = 48,
   parameter int SEC_UP_W      = 16,
   parameter int NS_W          = 30,
   parameter int QUO_W         = 8,
   parameter int FRAC_W        = 32,
   parameter int RST_QUO       = 8,
   parameter int RST_NUM       = 0,
   parameter int RST_DEN       = 1,
   parameter bit COHERENT_READ = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic        rd_en,
   input  logic [2:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        period_err
);
   localparam int SEC_LO_W = SEC_W - SEC_UP_W;
   localparam int T_W      = NS_W + 4;
   localparam logic [SEC_W-1:0] SEC_TOP = '1;

   initial begin
      AST_CFG_SPLIT: assert (SEC_LO_W == 32 && SEC_UP_W <= 32)
         else $error("seconds split must leave 32 lower bits");
      AST_CFG_NS: assert (NS_W >= 30 && NS_W <= 31)
         else $error("nanosecond field must hold one second");
      AST_CFG_STEP: assert (QUO_W <= 32 && FRAC_W <= 32 && QUO_W + 1 < T_W)
         else $error("step fields exceed the register width");
   end

   logic [NS_W-1:0]   st_ns;
   logic              st_neg;
   logic [SEC_W-1:0]  st_sec;
   logic [QUO_W-1:0]  st_quo;
   logic [FRAC_W-1:0] st_num, st_den;
   commit_t           commit;

   ptp_shadow_regs #(
      .NS_W(NS_W), .SEC_UP_W(SEC_UP_W), .SEC_W(SEC_W),
      .QUO_W(QUO_W), .FRAC_W(FRAC_W)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .st_ns(st_ns), .st_neg(st_neg), .st_sec(st_sec),
      .st_quo(st_quo), .st_num(st_num), .st_den(st_den), .commit(commit)
   );

   logic [SEC_W-1:0]  sec_q;
   logic [NS_W-1:0]   ns_q;
   logic [QUO_W-1:0]  quo_q;
   logic [FRAC_W-1:0] num_q, den_q;
   logic              running, carry;

   assign running    = (den_q != '0);
   assign period_err = !running;

   ptp_frac_accum #(.FRAC_W(FRAC_W)) u_frac (
      .clk(clk), .rst_n(rst_n), .run(running && !commit.load),
      .clear(commit.period), .num(num_q), .den(den_q), .carry(carry)
   );

   logic [QUO_W:0]        step;
   logic signed [T_W-1:0] mag_s, off_s, t_ns;
   logic [SEC_W-1:0]      base_sec, sec_nx;
   logic [NS_W-1:0]       ns_nx;

   always_comb begin
      step  = running ? ({1'b0, quo_q} + (QUO_W+1)'(carry)) : '0;
      mag_s = $signed(T_W'(st_ns[29:0]));
      off_s = !commit.offset ? '0 : (st_neg ? -mag_s : mag_s);
      if (commit.load) begin
         t_ns     = $signed(T_W'(st_ns));
         base_sec = st_sec;
      end else begin
         t_ns     = $signed(T_W'(ns_q)) + $signed(T_W'(step)) + off_s;
         base_sec = sec_q;
      end
   end

   ptp_tod_norm #(.SEC_W(SEC_W), .NS_W(NS_W), .T_W(T_W)) u_norm (
      .base_sec(base_sec), .t_ns(t_ns), .sec_out(sec_nx), .ns_out(ns_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= '0;
         ns_q  <= '0;
         quo_q <= QUO_W'(RST_QUO);
         num_q <= FRAC_W'(RST_NUM);
         den_q <= FRAC_W'(RST_DEN);
      end else begin
         sec_q <= sec_nx;
         ns_q  <= ns_nx;
         if (commit.period) begin
            quo_q <= st_quo;
            num_q <= st_num;
            den_q <= st_den;
         end
      end
   end

   logic [SEC_W-1:0] rd_sec;
   generate
      if (COHERENT_READ) begin : g_snap
         logic [SEC_W-1:0] snap_q;
         always_ff @(posedge clk) begin
            if (!rst_n) snap_q <= '0;
            else if (rd_en && tod_addr_e'(rd_addr) == ADR_NS) snap_q <= sec_q;
         end
         assign rd_sec = snap_q;
      end else begin : g_live
         assign rd_sec = sec_q;
      end
   endgenerate

   always_comb begin
      case (tod_addr_e'(rd_addr))
         ADR_NS:       rd_data = 32'(ns_q);
         ADR_SEC_UP:   rd_data = 32'(rd_sec[SEC_W-1:SEC_LO_W]);
         ADR_SEC_LOW:  rd_data = rd_sec[SEC_LO_W-1:0];
         ADR_STEP_INT: rd_data = 32'(quo_q);
         ADR_STEP_NUM: rd_data = 32'(num_q);
         ADR_STEP_DEN: rd_data = 32'(den_q);
         default:      rd_data = '0;
      endcase
   end

   AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ns_q < NS_PER_SEC); // R4
   AST_FROZEN_ZERO_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      (period_err && commit == '0) |=> (ns_q == $past(ns_q) && sec_q == $past(sec_q))); // R9
   AST_STEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit.period |=> (quo_q == $past(quo_q) && num_q == $past(num_q) && den_q == $past(den_q))); // R5
   AST_TIME_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && commit == '0 && sec_q < SEC_TOP - SEC_W'(2))
      |=> ({sec_q, ns_q} >= $past({sec_q, ns_q}))); // R2
endmodule

// File: tb/sim_ptp_tod_clock.sv
`timescale 1ns/1ps
module sim_ptp_tod_clock;
   localparam logic [95:0] BIL = 96'd1_000_000_000;
   localparam logic [95:0] MOD = (96'd1 << 48) * BIL;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic period_err;

   int total = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ptp_tod_clock u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .period_err(period_err)
   );

   // ---------------- reference model: total nanoseconds ----------------
   logic [95:0] m_base;
   longint      m_k;
   logic [95:0] m_quo, m_num, m_den;
   logic [95:0] s_ns, s_sec, s_quo, s_num, s_den;
   bit          s_neg;

   function automatic logic [95:0] elapsed(longint k, logic [95:0] q, logic [95:0] n, logic [95:0] d);
      logic [95:0] kk = 96'(k);
      if (d == 0) return q * kk;
      return q * kk + (n * kk) / d;
   endfunction

   function automatic logic [95:0] m_now();
      return (m_base + elapsed(m_k, m_quo, m_num, m_den)) % MOD;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_base = 0; m_k = 0; m_quo = 8; m_num = 0; m_den = 1;
         s_ns = 0; s_sec = 0; s_quo = 0; s_num = 0; s_den = 0; s_neg = 0;
      end else begin
         bit ld, of, pe;
         longint nk;
         logic [95:0] cur;
         ld = wr_en && wr_addr == 3'd7 && wr_data[0];
         of = wr_en && wr_addr == 3'd7 && wr_data[1];
         pe = wr_en && wr_addr == 3'd7 && wr_data[2];
         nk = (m_den != 0 && !ld) ? m_k + 1 : m_k;
         cur = (m_base + elapsed(nk, m_quo, m_num, m_den)) % MOD;
         if (ld) cur = (s_sec * BIL + s_ns) % MOD;
         else if (of) cur = s_neg ? (cur + MOD - s_ns) % MOD : (cur + s_ns) % MOD;
         if (pe) begin
            m_quo = s_quo; m_num = s_num; m_den = s_den; m_k = 0; m_base = cur;
         end else begin
            m_k = nk;
            m_base = (cur + MOD - elapsed(nk, m_quo, m_num, m_den) % MOD) % MOD;
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin s_ns = 96'(wr_data[29:0]); s_neg = wr_data[31]; end
               3'd1: s_sec = {s_sec[95:48], 32'(wr_data[15:0]), s_sec[31:0]} & ((96'd1 << 48) - 1);
               3'd2: s_sec = {s_sec[95:32], wr_data};
               3'd3: s_quo = 96'(wr_data[7:0]);
               3'd4: s_num = 96'(wr_data);
               3'd5: s_den = 96'(wr_data);
               default: ;
            endcase
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic read_time(input string req);
      logic [31:0] ns, hi, lo;
      logic [95:0] e;
      rd_en = 1'b1; rd_addr = 3'd0; #1; ns = rd_data; e = m_now();
      @(negedge clk);
      rd_en = 1'b0;
      rd(3'd1, hi); rd(3'd2, lo);
      chk({req, " ns"}, 64'(ns), 64'(e % BIL));
      chk({req, " sec"}, {16'h0, hi[15:0], lo}, 64'(e / BIL));
   endtask

   task automatic set_step(input int q, input int n, input int d);
      wr(3'd3, 32'(q)); wr(3'd4, 32'(n)); wr(3'd5, 32'(d)); wr(3'd7, 32'h4);
   endtask

   task automatic load(input logic [47:0] sec, input logic [31:0] ns);
      wr(3'd1, 32'(sec[47:32])); wr(3'd2, sec[31:0]); wr(3'd0, ns); wr(3'd7, 32'h1);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(3'd0, v); chk("R1 ns at reset", 64'(v), 0);
      rd(3'd3, v); chk("R1 step int", 64'(v), 8);
      rd(3'd4, v); chk("R1 step num", 64'(v), 0);
      rd(3'd5, v); chk("R1 step den", 64'(v), 1);
      chk("R1 period_err", 64'(period_err), 0);
      read_time("R1 early");
      // R2 integer advance
      repeat (20) @(negedge clk);
      read_time("R2 integer");
      // R5 staging without commit
      wr(3'd3, 32'd5); wr(3'd0, 32'd123); wr(3'd2, 32'd77);
      rd(3'd3, v); chk("R5 step int unchanged", 64'(v), 8);
      read_time("R5 time untouched");
      // R2/R3/R8 near-exhaustive sweep of small steps
      for (int q = 0; q < 3; q++)
         for (int d = 1; d < 5; d++)
            for (int n = 0; n < d; n++) begin
               set_step(q, n, d);
               rd(3'd4, v); chk("R8 active num", 64'(v), 64'(n));
               repeat (3 + n + 2 * d) @(negedge clk);
               read_time("R2 fractional sweep");
            end
      // R6 absolute load, no advance at load edge
      set_step(8, 0, 1);
      load(48'h1234_89AB_CDEF, 32'd999_999_990);
      rd(3'd0, v); chk("R6 ns exact at load", 64'(v), 64'd999_999_990);
      read_time("R6 load");
      repeat (4) @(negedge clk);
      read_time("R4 rollover");
      // R6 out-of-range ns carries
      load(48'd50, 32'd1_000_000_005);
      rd(3'd0, v); chk("R6 ns carry", 64'(v), 64'd5);
      read_time("R6 carry sec");
      // R4 seconds wrap
      load(48'hFFFF_FFFF_FFFF, 32'd999_999_995);
      repeat (3) @(negedge clk);
      read_time("R4 wrap");
      // R7 positive offset on a rollover edge with fractional step
      set_step(2, 1, 2);
      load(48'd7, 32'd999_999_998);
      wr(3'd0, 32'd3); wr(3'd7, 32'h2);
      read_time("R7 offset at rollover");
      // R7 negative double borrow
      load(48'd10, 32'd100);
      wr(3'd0, 32'h8000_0000 | 32'd1_073_741_823); wr(3'd7, 32'h2);
      read_time("R7 double borrow");
      // R7 load wins over offset
      wr(3'd0, 32'h0000_0500); wr(3'd2, 32'd3); wr(3'd1, 32'd0);
      wr(3'd7, 32'h3);
      rd(3'd0, v); chk("R7 offset dropped with load", 64'(v), 64'h500);
      read_time("R7 load and offset");
      // R7/R8 offset and step change on one edge
      wr(3'd3, 32'd3); wr(3'd4, 32'd1); wr(3'd5, 32'd3); wr(3'd0, 32'd999_999_999);
      wr(3'd7, 32'h6);
      repeat (7) @(negedge clk);
      read_time("R8 offset with step change");
      // R9 zero denominator
      set_step(4, 0, 0);
      chk("R9 period_err", 64'(period_err), 1);
      rd(3'd0, v);
      repeat (10) @(negedge clk);
      rd(3'd0, v2); chk("R9 frozen", 64'(v2), 64'(v));
      wr(3'd0, 32'd40); wr(3'd7, 32'h2);
      read_time("R9 offset while frozen");
      set_step(8, 0, 1);
      chk("R9 flag cleared", 64'(period_err), 0);
      // R10 coherent seconds capture
      load(48'd20, 32'd5);
      rd_en = 1'b1; rd_addr = 3'd0; #1;
      @(negedge clk); rd_en = 1'b0;
      load(48'd900, 32'd5);
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R10 captured seconds held", 64'(v), 64'd20);
      read_time("R10 fresh capture");
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule